// File: doc/BRIEF.md
# Page-Write Nonvolatile Memory Controller

This block models the write engine of a byte-wide electrically erasable memory as synchronous logic. It watches three active-low strobes (chip select, write enable, output enable) driven by an external bus master. Each strobe passes through a two-stage synchronizer before any edge is detected. Bytes written by the master collect in a page buffer. A retriggerable load-window timer decides when the page is complete. When the window runs out, the loaded bytes of the page are programmed into a backing array during a busy period of fixed length.

While the block is busy, a read returns the last byte written with its top bit inverted. A master can poll that bit to learn when programming has finished. The window and busy lengths are parameters counted in clock cycles, so a simulation can use short values and a real build can use long ones. Software protection schemes and power sensing are not part of the block.

Top module: `eep_page_writer`

## Requirements
- R1: After reset, busy_o and data_oe_o are 0 and every array location reads as 8'hFF.
- R2: A write cycle opens only while output enable is high and both chip select and write enable are low. Strobing write enable while output enable is low stores nothing. A load window that expires with no byte loaded does not raise busy_o.
- R3: The address is taken when the write cycle opens, that is, when the later of chip select and write enable falls. The data is taken when the cycle closes, that is, when the earlier of the two rises. This holds for both write-enable-controlled and chip-select-controlled cycles.
- R4: Each falling edge of write enable restarts the load-window timer from zero, and the timer is held at zero while a write cycle is open. busy_o rises about LOAD_CYC cycles after the last write cycle closes, give or take a few synchronizer cycles. A byte that follows the previous one in less than LOAD_CYC cycles joins the same page without raising busy_o.
- R5: When the window expires, every loaded byte is programmed. busy_o then stays high for exactly BUSY_CYC cycles, whether one byte or several were loaded. After that, reads return the new data.
- R6: While busy_o is high, a read at any address returns the last byte written with bit 7 inverted and bits 6:0 unchanged. After busy_o falls, reads return the true stored data.
- R7: data_oe_o is 1 only while chip select and output enable are low and write enable is high. In every other case data_oe_o is 0 and data_o is 8'h00.
- R8: Write strobes that arrive while busy_o is high change neither the page buffer, the timers nor the array, and no new busy period follows from them.
- R9: The page is set by the upper address bits (ADDR_W-1:7) of the first byte in a load. Later bytes in the same load use only their low 7 address bits and land in that first page.
- R10: busy_o rises only in the cycle after the load window expires with at least one byte loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip select, active low, asynchronous to the clock |
| we_ni | input | 1 | Write enable, active low, asynchronous to the clock |
| oe_ni | input | 1 | Output enable, active low, asynchronous to the clock |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data; 0 when not driven |
| data_oe_o | output | 1 | Read data valid / drive enable |
| busy_o | output | 1 | High from load-window expiry until the commit finishes |

## Verification
A stale or misplaced page tag shows up as a byte read back from the wrong page, as soon as the busy period ends. A timer that fails to restart shows as busy_o rising in the middle of a multi-byte load, within one window length of that load starting. A faulty busy counter changes the exact length of the busy pulse. A wrong polling latch shows on the first read made while busy. Capture taken on the wrong strobe edge shows as data or an address that the bench changed mid-cycle being written in place of the intended ones.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W   = 8;
  localparam int POLL_BIT = 7;
  localparam logic [BYTE_W-1:0] ERASED = 8'hFF;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } strobe_t;
endpackage

// File: rtl/eep_strobe_sync.sv
module eep_strobe_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= RST_VAL[g];
        s2_q[g] <= RST_VAL[g];
        s3_q[g] <= RST_VAL[g];
      end else begin
        s1_q[g] <= d_i[g];
        s2_q[g] <= s1_q[g];
        s3_q[g] <= s2_q[g];
      end
    end
  end

  assign q_o      = s2_q;
  assign q_prev_o = s3_q;
endmodule

// File: rtl/eep_cycle_timer.sv
module eep_cycle_timer #(
  parameter int CYC = 16,
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic running_o,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (at_end) run_q <= 1'b0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign running_o = run_q;
  assign expire_o  = run_q && at_end && !restart_i;

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (int'(cnt_q) < CYC));
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 7,
  parameter int DW     = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              clr_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_valid_o,
  output logic              any_valid_o
);
  logic [DW-1:0]         bytes_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bytes_q[g] <= '0;
        valid_q[g] <= 1'b0;
      end else if (clr_i) begin
        valid_q[g] <= 1'b0;
      end else if (wr_en_i && (wr_idx_i == PAGE_W'(g))) begin
        bytes_q[g] <= wr_data_i;
        valid_q[g] <= 1'b1;
      end
    end
  end

  assign rd_data_o   = bytes_q[rd_idx_i];
  assign rd_valid_o  = valid_q[rd_idx_i];
  assign any_valid_o = |valid_q;
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer #(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 7,
  parameter int LOAD_CYC = 15000,
  parameter int BUSY_CYC = 1000000,
  localparam int DW         = eep_pkg::BYTE_W,
  localparam int MEM_DEPTH  = 1 << ADDR_W,
  localparam int TAG_W      = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  output logic              busy_o
);
  import eep_pkg::*;

  // BUSY_CYC must exceed 1 << PAGE_W so the commit walk completes inside busy.
  strobe_t stb_raw, stb, stb_prev;
  assign stb_raw = '{ce_n: ce_ni, we_n: we_ni, oe_n: oe_ni};

  eep_strobe_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (stb_raw),
    .q_o      (stb),
    .q_prev_o (stb_prev)
  );

  logic busy, busy_start, busy_end;
  logic load_restart, load_expire, load_run;
  logic wr_now, wr_was, cyc_start, cyc_close, we_fall;
  logic cyc_open_q;
  logic [ADDR_W-1:0] cyc_addr_q;
  logic [TAG_W-1:0]  page_q;
  logic [DW-1:0]     last_q;
  logic [PAGE_W:0]   cidx_q;
  logic              commit_act;
  logic [DW-1:0]     buf_rd_data;
  logic              buf_rd_valid, any_valid;

  assign wr_now    = !stb.ce_n && !stb.we_n && stb.oe_n;
  assign wr_was    = !stb_prev.ce_n && !stb_prev.we_n && stb_prev.oe_n;
  assign cyc_start = wr_now && !wr_was && !busy && !cyc_open_q;
  assign cyc_close = cyc_open_q && (stb.ce_n || stb.we_n);
  assign we_fall   = stb_prev.we_n && !stb.we_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_open_q <= 1'b0;
      cyc_addr_q <= '0;
    end else if (cyc_start) begin
      cyc_open_q <= 1'b1;
      cyc_addr_q <= addr_i;
    end else if (cyc_close) begin
      cyc_open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      last_q <= '0;
    end else if (cyc_close) begin
      if (!any_valid) page_q <= cyc_addr_q[ADDR_W-1:PAGE_W];
      last_q <= data_i;
    end
  end

  assign load_restart = (we_fall || cyc_open_q) && !busy;

  eep_cycle_timer #(.CYC(LOAD_CYC)) u_load_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_restart),
    .running_o (load_run),
    .expire_o  (load_expire)
  );

  assign busy_start = load_expire && any_valid;

  eep_cycle_timer #(.CYC(BUSY_CYC)) u_busy_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (busy_start),
    .running_o (busy),
    .expire_o  (busy_end)
  );

  eep_page_buf #(.PAGE_W(PAGE_W), .DW(DW)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (cyc_close),
    .wr_idx_i    (cyc_addr_q[PAGE_W-1:0]),
    .wr_data_i   (data_i),
    .clr_i       (busy_end),
    .rd_idx_i    (cidx_q[PAGE_W-1:0]),
    .rd_data_o   (buf_rd_data),
    .rd_valid_o  (buf_rd_valid),
    .any_valid_o (any_valid)
  );

  // Commit walk: one page slot per cycle at the start of busy.
  assign commit_act = busy && !cidx_q[PAGE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cidx_q <= '0;
    else if (busy_start) cidx_q <= '0;
    else if (commit_act) cidx_q <= cidx_q + 1'b1;
  end

  logic [DW-1:0] mem_q [MEM_DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= ERASED;
    end else if (commit_act && buf_rd_valid) begin
      mem_q[{page_q, cidx_q[PAGE_W-1:0]}] <= buf_rd_data;
    end
  end

  logic          rd_en;
  logic          oe_q;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] poll_val;

  assign rd_en    = !stb.ce_n && !stb.oe_n && stb.we_n;
  assign poll_val = last_q ^ (DW'(1) << POLL_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q <= 1'b0;
      rd_q <= '0;
    end else begin
      oe_q <= rd_en;
      rd_q <= busy ? poll_val : mem_q[addr_i];
    end
  end

  assign data_oe_o = oe_q;
  assign data_o    = oe_q ? rd_q : '0;
  assign busy_o    = busy;

  assert_busy_from_expiry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(load_expire));

  assert_no_capture_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cyc_close);

  assert_page_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !any_valid);

  assert_poll_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && data_oe_o) |-> (data_o[POLL_BIT] != last_q[POLL_BIT]));

  assert_timer_idle_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_run);
endmodule

// File: tb/tb_eep_page_writer.sv
`timescale 1ns/1ps
module tb_eep_page_writer;
  localparam int LOAD = 64;
  localparam int BUSY = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic doe, busy;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eep_page_writer #(.ADDR_W(10), .PAGE_W(7), .LOAD_CYC(LOAD), .BUSY_CYC(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe), .busy_o(busy)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d, input bit ce_ctl);
    addr = a; din = d; oe_n = 1'b1;
    if (ce_ctl) begin
      we_n = 1'b0; cyc(3); ce_n = 1'b0; cyc(6); ce_n = 1'b1; cyc(6); we_n = 1'b1;
    end else begin
      ce_n = 1'b0; cyc(3); we_n = 1'b0; cyc(6); we_n = 1'b1; cyc(6); ce_n = 1'b1;
    end
    cyc(2);
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d, output logic e);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    cyc(6);
    d = dout; e = doe;
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(3);
  endtask

  task automatic wait_busy(input string what);
    int t = 0;
    while (!busy && t < 4 * LOAD) begin cyc(1); t++; end
    chk(what, busy, 1);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 2 * BUSY) begin cyc(1); t++; end
    cyc(2);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic e;
    chk("R1 busy_o after reset", busy, 0);
    chk("R1 data_oe_o after reset", doe, 0);
    rd(10'h000, d, e);
    chk("R1 erased read at 0x000", d, 8'hFF);
    rd(10'h3FF, d, e);
    chk("R1 erased read at 0x3FF", d, 8'hFF);
  endtask

  task automatic t_oe_inhibit();
    logic [7:0] d; logic e;
    addr = 10'h030; din = 8'h99;
    oe_n = 1'b0; ce_n = 1'b0; cyc(3);
    we_n = 1'b0; cyc(6); we_n = 1'b1; cyc(4);
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(LOAD + 20);
    chk("R2 no busy after inhibited write", busy, 0);
    rd(10'h030, d, e);
    chk("R2 inhibited write stored nothing", d, 8'hFF);
  endtask

  task automatic t_ce_ctl();
    logic [7:0] d; logic e; int len = 0;
    wr(10'h010, 8'hA5, 1'b1);
    wait_busy("R10 busy after CE-controlled write");
    while (busy && len < 2 * BUSY) begin cyc(1); len++; end
    chk("R5 busy length one byte", len, BUSY);
    cyc(2);
    rd(10'h010, d, e);
    chk("R3 CE-controlled write data", d, 8'hA5);
    chk("R7 data_oe_o during read", e, 1);
  endtask

  task automatic t_skew();
    logic [7:0] d; logic e;
    addr = 10'h020; din = 8'h11; oe_n = 1'b1;
    ce_n = 1'b0; cyc(3); we_n = 1'b0; cyc(6);
    addr = 10'h3FF; din = 8'h5A; cyc(3);
    we_n = 1'b1; cyc(6);
    din = 8'h11; ce_n = 1'b1; cyc(2);
    wait_busy("R10 busy after skewed write");
    wait_idle();
    rd(10'h020, d, e);
    chk("R3 address at open, data at close", d, 8'h5A);
    rd(10'h3FF, d, e);
    chk("R3 late address not written", d, 8'hFF);
  endtask

  task automatic t_retrigger();
    logic [7:0] d; logic e; int t = 0; int len = 0;
    wr(10'h040, 8'h01, 1'b0);
    cyc(40);
    chk("R4 no busy inside window after byte 0", busy, 0);
    wr(10'h041, 8'h02, 1'b0);
    cyc(40);
    chk("R4 no busy inside window after byte 1", busy, 0);
    wr(10'h042, 8'h03, 1'b0);
    while (!busy && t < 4 * LOAD) begin cyc(1); t++; end
    chk("R4 window expiry time lower bound", (t >= LOAD - 10), 1);
    chk("R4 window expiry time upper bound", (t <= LOAD + 4), 1);
    while (busy && len < 2 * BUSY) begin cyc(1); len++; end
    chk("R5 busy length three bytes", len, BUSY);
    cyc(2);
    rd(10'h040, d, e); chk("R5 page byte 0", d, 8'h01);
    rd(10'h041, d, e); chk("R5 page byte 1", d, 8'h02);
    rd(10'h042, d, e); chk("R5 page byte 2", d, 8'h03);
  endtask

  task automatic t_poll(input logic [9:0] a, input logic [7:0] v);
    logic [7:0] d; logic e;
    wr(a, v, 1'b0);
    wait_busy("R10 busy before poll");
    rd(a, d, e);
    chk("R6 poll at written address", d, {~v[7], v[6:0]});
    rd(10'h001, d, e);
    chk("R6 poll at other address", d, {~v[7], v[6:0]});
    wait_idle();
    rd(a, d, e);
    chk("R6 true data after busy", d, v);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d; logic e;
    wr(10'h0A0, 8'h77, 1'b0);
    wait_busy("R10 busy before ignored write");
    wr(10'h0B0, 8'h55, 1'b0);
    wait_idle();
    cyc(LOAD + 20);
    chk("R8 no new busy from write during busy", busy, 0);
    rd(10'h0B0, d, e);
    chk("R8 write during busy stored nothing", d, 8'hFF);
    rd(10'h0A0, d, e);
    chk("R8 earlier page intact", d, 8'h77);
  endtask

  task automatic t_page();
    logic [7:0] d; logic e;
    wr(10'h105, 8'h61, 1'b0);
    wr(10'h386, 8'h62, 1'b0);
    wait_busy("R10 busy after page load");
    wait_idle();
    rd(10'h105, d, e); chk("R9 first byte in page", d, 8'h61);
    rd(10'h106, d, e); chk("R9 second byte in first page", d, 8'h62);
    rd(10'h386, d, e); chk("R9 other page untouched", d, 8'hFF);
  endtask

  task automatic t_read_gate();
    addr = 10'h010; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    cyc(6);
    chk("R7 no drive with write enable low", doe, 0);
    chk("R7 data zero with write enable low", dout, 0);
    we_n = 1'b1; cyc(6);
    chk("R7 drive when selected and enabled", doe, 1);
    chk("R7 read data", dout, 8'hA5);
    ce_n = 1'b1; cyc(6);
    chk("R7 no drive when deselected", doe, 0);
    chk("R7 data zero when deselected", dout, 0);
    oe_n = 1'b1;
    cyc(LOAD + 20);
    chk("R2 empty window raises no busy", busy, 0);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_oe_inhibit();
    t_ce_ctl();
    t_skew();
    t_retrigger();
    t_poll(10'h0F3, 8'h3C);
    t_poll(10'h0F4, 8'hC7);
    t_busy_ignore();
    t_page();
    t_read_gate();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule